// File: doc/BRIEF.md
# I2C Dual Own-Address Matcher

This block sits behind the bit-level front end of an I2C target and decides whether a received address byte is meant for this device. It holds two own-address settings. The primary address works as either a 7-bit or a 10-bit address. The secondary address is always 7 bits wide. Its mask code turns a growing number of low address bits into don't-care bits. While that mask is active, the block refuses the two reserved address groups. For every decision the block raises a one-cycle strobe. The strobe comes with the ACK/NACK verdict, a code naming the address that matched, and the read/write bit of the transfer.

Software sets up both addresses through a small write port. A write is applied `APPLY_LAT` cycles after the port accepts it. A second write presented during that time is held off with a wait signal. The address value of each setting, together with its mode or mask, is frozen while that setting is enabled. Its enable bit can always be written. For 10-bit operation the block expects two bytes: a header byte followed by the low address byte. It gives its verdict only after the second byte.

Top module: `i2c_own_addr_match`

## Requirements
- R1: After reset both settings are disabled and all fields are zero. Every first address byte then produces a strobe with NACK and match code 0. The wait output is 0.
- R2: Primary setting, written with `cfg_sel`=0: enable is bit 15, mode is bit 10, the address is bits [9:0]. With mode 0, the byte bits [7:1] are compared against address bits [7:1], and address bits 9, 8 and 0 play no part. A hit gives ACK with match code 1, and `match_rw` equals byte bit 0.
- R3: With the primary setting enabled in mode 1, a header byte of the form 11110, address bits [9:8], R/W produces no strobe. The next non-first byte then gives a strobe. That strobe is ACK with code 1 when the byte equals address bits [7:0], and NACK with code 0 otherwise. `match_rw` is the header's bit 0.
- R4: A write to the primary setting while it is enabled leaves the mode and the address unchanged, and still updates the enable bit.
- R5: Secondary setting, written with `cfg_sel`=1: enable is bit 15, the mask code n is bits [10:8], the address is bits [7:1]. Byte bits [7:n+1] must equal the stored bits. Code 7 compares nothing. A hit gives ACK with match code 2.
- R6: With a nonzero mask code, bytes whose bits [7:4] are 0000 or 1111 are never acknowledged through the secondary setting. With mask code 0 they are compared like any other address.
- R7: A write to the secondary setting while it is enabled leaves the mask code and the address unchanged, and still updates the enable bit.
- R8: When a 7-bit byte hits both settings, the block reports code 1. A byte that matches a 10-bit header goes to the 10-bit sequence, even if the secondary setting would also match it.
- R9: A write is accepted when no earlier write is still being applied. It takes effect `APPLY_LAT` cycles after acceptance. While a write is pending, `cfg_wait` is high for as long as `cfg_wr_en` is high, and the held write is accepted once the pending write has been applied.
- R10: A strobe lasts one cycle and follows, one cycle later, the byte that completes a decision. A non-first byte that arrives while no 10-bit header is pending produces no strobe. A new first byte abandons a pending header.
- R11: While the secondary setting is disabled, a byte that it would otherwise match is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block on a clock edge |
| cfg_wr_en | input | 1 | Configuration write request, held until `cfg_wait` is low |
| cfg_sel | input | 1 | 0 selects the primary setting, 1 selects the secondary setting |
| cfg_wdata | input | 16 | Write data, fields as listed in R2 and R5 |
| cfg_wait | output | 1 | Write stalled because an earlier write is still being applied |
| addr_byte_vld | input | 1 | One-cycle qualifier for `addr_byte` |
| addr_first | input | 1 | The byte is the first one after a START or repeated START |
| addr_byte | input | 8 | Received byte: address in bits [7:1], R/W in bit 0 for a first byte |
| match_vld | output | 1 | One-cycle decision strobe |
| match_ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| match_id | output | 2 | 0 none, 1 primary setting, 2 secondary setting |
| match_rw | output | 1 | R/W bit of the decided transfer |

## Verification
The hardest states to reach are the ones that combine the two settings. Examples are a 10-bit header that the secondary setting would also accept, a header abandoned by a new START, and a locked field written with new contents. Directed sequences set up each of these. Random configuration writes then feed a model that applies the same locking rules. Random address bytes are steered toward the stored addresses, toward 10-bit headers and toward the reserved groups, so hits and reserved cases occur often.

// File: rtl/i2c_oam_pkg.sv
package i2c_oam_pkg;
  localparam int unsigned CFG_W     = 16;
  localparam int unsigned PRI_W     = 10;
  localparam int unsigned SEC_W     = 7;
  localparam int unsigned MSK_W     = 3;
  localparam int unsigned EN_BIT    = 15;
  localparam int unsigned MODE_BIT  = 10;
  localparam int unsigned MSK_LSB   = 8;

  typedef enum logic [1:0] {
    MID_NONE = 2'd0,
    MID_PRI  = 2'd1,
    MID_SEC  = 2'd2
  } match_id_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_HDR  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/oam_cfg_regs.sv
module oam_cfg_regs
  import i2c_oam_pkg::*;
#(
  parameter int unsigned APPLY_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [CFG_W-1:0]     wr_data,
  output logic                 wr_wait,
  output logic                 busy,
  output logic                 pri_en,
  output logic                 pri_mode10,
  output logic [PRI_W-1:0]     pri_addr,
  output logic                 sec_en,
  output logic [MSK_W-1:0]     sec_msk,
  output logic [SEC_W-1:0]     sec_addr
);
  localparam int unsigned CW = $clog2(APPLY_LAT + 1);
  localparam int unsigned PW = MODE_BIT + 1;

  logic [CW-1:0]      cnt_q, cnt_d;
  logic               psel_q, psel_d;
  logic               pen_q, pen_d;
  logic [PW-1:0]      pdat_q, pdat_d;
  logic               pri_en_d, pri_mode_d, sec_en_d;
  logic [PRI_W-1:0]   pri_addr_d;
  logic [MSK_W-1:0]   sec_msk_d;
  logic [SEC_W-1:0]   sec_addr_d;
  logic               accept;
  logic [3:0]         unused_wdata;

  assign unused_wdata = wr_data[EN_BIT-1:PW];
  assign busy    = (cnt_q != '0);
  assign accept  = wr_en && !busy;
  assign wr_wait = wr_en && busy;

  always_comb begin
    cnt_d      = cnt_q;
    psel_d     = psel_q;
    pen_d      = pen_q;
    pdat_d     = pdat_q;
    pri_en_d   = pri_en;
    pri_mode_d = pri_mode10;
    pri_addr_d = pri_addr;
    sec_en_d   = sec_en;
    sec_msk_d  = sec_msk;
    sec_addr_d = sec_addr;
    if (accept) begin
      cnt_d  = CW'(APPLY_LAT);
      psel_d = wr_sel;
      pen_d  = wr_data[EN_BIT];
      pdat_d = wr_data[PW-1:0];
    end else if (busy) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        if (!psel_q) begin
          if (!pri_en) begin
            pri_mode_d = pdat_q[MODE_BIT];
            pri_addr_d = pdat_q[PRI_W-1:0];
          end
          pri_en_d = pen_q;
        end else begin
          if (!sec_en) begin
            sec_msk_d  = pdat_q[MSK_LSB +: MSK_W];
            sec_addr_d = pdat_q[SEC_W:1];
          end
          sec_en_d = pen_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      psel_q     <= 1'b0;
      pen_q      <= 1'b0;
      pdat_q     <= '0;
      pri_en     <= 1'b0;
      pri_mode10 <= 1'b0;
      pri_addr   <= '0;
      sec_en     <= 1'b0;
      sec_msk    <= '0;
      sec_addr   <= '0;
    end else begin
      cnt_q      <= cnt_d;
      psel_q     <= psel_d;
      pen_q      <= pen_d;
      pdat_q     <= pdat_d;
      pri_en     <= pri_en_d;
      pri_mode10 <= pri_mode_d;
      pri_addr   <= pri_addr_d;
      sec_en     <= sec_en_d;
      sec_msk    <= sec_msk_d;
      sec_addr   <= sec_addr_d;
    end
  end
endmodule

// File: rtl/oam_sec_cmp.sv
module oam_sec_cmp
  import i2c_oam_pkg::*;
(
  input  logic             en,
  input  logic [MSK_W-1:0] msk,
  input  logic [SEC_W-1:0] own,
  input  logic [SEC_W-1:0] rx,
  output logic             hit
);
  logic [SEC_W-1:0] care;
  logic             reserved;

  for (genvar i = 0; i < SEC_W; i++) begin : g_care
    assign care[i] = (i >= int'(msk));
  end

  assign reserved = (rx[SEC_W-1:SEC_W-4] == 4'b0000) ||
                    (rx[SEC_W-1:SEC_W-4] == 4'b1111);
  assign hit = en && (((rx ^ own) & care) == '0) &&
               !((msk != '0) && reserved);
endmodule

// File: rtl/oam_seq.sv
module oam_seq
  import i2c_oam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             first,
  input  logic [7:0]       rx_byte,
  input  logic             pri_en,
  input  logic             pri_mode10,
  input  logic [PRI_W-1:0] pri_addr,
  input  logic             sec_hit,
  output logic             m_vld,
  output logic             m_ack,
  output match_id_e        m_id,
  output logic             m_rw,
  output seq_state_e       state
);
  seq_state_e st_d;
  logic       hrw_q, hrw_d;
  logic       vld_d, ack_d, rw_d;
  match_id_e  id_d;
  logic       hdr_hit, pri7_hit;

  assign hdr_hit  = pri_en && pri_mode10 && (rx_byte[7:3] == 5'b11110) &&
                    (rx_byte[2:1] == pri_addr[9:8]);
  assign pri7_hit = pri_en && !pri_mode10 && (rx_byte[7:1] == pri_addr[7:1]);

  always_comb begin
    st_d  = state;
    hrw_d = hrw_q;
    vld_d = 1'b0;
    ack_d = 1'b0;
    id_d  = MID_NONE;
    rw_d  = m_rw;
    if (byte_vld && first) begin
      if (hdr_hit) begin
        st_d  = SQ_HDR;
        hrw_d = rx_byte[0];
      end else begin
        st_d  = SQ_IDLE;
        vld_d = 1'b1;
        rw_d  = rx_byte[0];
        if (pri7_hit) begin
          ack_d = 1'b1;
          id_d  = MID_PRI;
        end else if (sec_hit) begin
          ack_d = 1'b1;
          id_d  = MID_SEC;
        end
      end
    end else if (byte_vld && (state == SQ_HDR)) begin
      st_d  = SQ_IDLE;
      vld_d = 1'b1;
      rw_d  = hrw_q;
      if (rx_byte == pri_addr[7:0]) begin
        ack_d = 1'b1;
        id_d  = MID_PRI;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      hrw_q <= 1'b0;
      m_vld <= 1'b0;
      m_ack <= 1'b0;
      m_id  <= MID_NONE;
      m_rw  <= 1'b0;
    end else begin
      state <= st_d;
      hrw_q <= hrw_d;
      m_vld <= vld_d;
      m_ack <= ack_d;
      m_id  <= id_d;
      m_rw  <= rw_d;
    end
  end
endmodule

// File: rtl/i2c_own_addr_match.sv
module i2c_own_addr_match
  import i2c_oam_pkg::*;
#(
  parameter int unsigned APPLY_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic        cfg_wait,
  input  logic        addr_byte_vld,
  input  logic        addr_first,
  input  logic [7:0]  addr_byte,
  output logic        match_vld,
  output logic        match_ack,
  output logic [1:0]  match_id,
  output logic        match_rw
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             cfg_busy;
  logic             pri_en, pri_mode10, sec_en, sec_hit;
  logic [PRI_W-1:0] pri_addr;
  logic [MSK_W-1:0] sec_msk;
  logic [SEC_W-1:0] sec_addr;
  match_id_e        id_e;
  seq_state_e       seq_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  oam_cfg_regs #(.APPLY_LAT(APPLY_LAT)) u_cfg (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(cfg_wr_en), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .wr_wait(cfg_wait), .busy(cfg_busy),
    .pri_en(pri_en), .pri_mode10(pri_mode10), .pri_addr(pri_addr),
    .sec_en(sec_en), .sec_msk(sec_msk), .sec_addr(sec_addr)
  );

  oam_sec_cmp u_sec (
    .en(sec_en), .msk(sec_msk), .own(sec_addr),
    .rx(addr_byte[7:1]), .hit(sec_hit)
  );

  oam_seq u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .byte_vld(addr_byte_vld), .first(addr_first), .rx_byte(addr_byte),
    .pri_en(pri_en), .pri_mode10(pri_mode10), .pri_addr(pri_addr),
    .sec_hit(sec_hit),
    .m_vld(match_vld), .m_ack(match_ack), .m_id(id_e), .m_rw(match_rw),
    .state(seq_state)
  );

  assign match_id = id_e;
endmodule

// File: rtl/oam_checker.sv
module oam_checker
  import i2c_oam_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             first,
  input logic [3:0]       byte_hi,
  input logic             m_vld,
  input logic             m_ack,
  input logic [1:0]       m_id,
  input logic             wr_en,
  input logic             wr_wait,
  input logic             busy,
  input logic             pri_en,
  input logic             pri_mode10,
  input logic [PRI_W-1:0] pri_addr,
  input logic             sec_en,
  input logic [MSK_W-1:0] sec_msk,
  input logic [SEC_W-1:0] sec_addr,
  input logic             hdr_pend
);
  assert_strobe_follows_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_vld |-> $past(byte_vld));

  assert_no_strobe_from_stray_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !first && !hdr_pend) |=> !m_vld);

  assert_nack_has_no_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_vld && !m_ack) |-> (m_id == 2'd0));

  assert_ack_names_setting_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_ack |-> (m_vld && (m_id != 2'd0)));

  assert_wait_only_on_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wait |-> (wr_en && busy));

  assert_accept_starts_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wait) |=> busy);

  assert_pri_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pri_en) |-> ($stable(pri_addr) && $stable(pri_mode10)));

  assert_sec_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_en) |-> ($stable(sec_addr) && $stable(sec_msk)));

  assert_reserved_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_vld && (m_id == 2'd2) && ($past(sec_msk) != '0)) |->
      (($past(byte_hi) != 4'b0000) && ($past(byte_hi) != 4'b1111)));

  assert_sec_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_vld && (m_id == 2'd2)) |-> $past(sec_en));
endmodule

bind i2c_own_addr_match oam_checker chk_i (
  .clk(clk), .rst_n(rst_n_s),
  .byte_vld(addr_byte_vld), .first(addr_first), .byte_hi(addr_byte[7:4]),
  .m_vld(match_vld), .m_ack(match_ack), .m_id(match_id),
  .wr_en(cfg_wr_en), .wr_wait(cfg_wait), .busy(cfg_busy),
  .pri_en(pri_en), .pri_mode10(pri_mode10), .pri_addr(pri_addr),
  .sec_en(sec_en), .sec_msk(sec_msk), .sec_addr(sec_addr),
  .hdr_pend(seq_state == i2c_oam_pkg::SQ_HDR)
);

// File: tb/i2c_own_addr_match_tb.sv
module i2c_own_addr_match_tb_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en, cfg_sel;
  logic [15:0] cfg_wdata;
  logic        cfg_wait;
  logic        addr_byte_vld, addr_first;
  logic [7:0]  addr_byte;
  logic        match_vld, match_ack, match_rw;
  logic [1:0]  match_id;

  int checks = 0;
  int errors = 0;

  logic       m_pen, m_pmode, m_sen, m_hdr, m_hrw;
  logic [9:0] m_paddr;
  logic [2:0] m_smsk;
  logic [6:0] m_saddr;

  always #4 clk = ~clk;

  i2c_own_addr_match #(.APPLY_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_wait(cfg_wait),
    .addr_byte_vld(addr_byte_vld), .addr_first(addr_first), .addr_byte(addr_byte),
    .match_vld(match_vld), .match_ack(match_ack), .match_id(match_id),
    .match_rw(match_rw)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic model_wr(logic sel, logic [15:0] d);
    if (!sel) begin
      if (!m_pen) begin m_pmode = d[10]; m_paddr = d[9:0]; end
      m_pen = d[15];
    end else begin
      if (!m_sen) begin m_smsk = d[10:8]; m_saddr = d[7:1]; end
      m_sen = d[15];
    end
  endtask

  function automatic logic sec_model(logic [6:0] a);
    if (!m_sen) return 1'b0;
    if (m_smsk != 3'd0 && (a[6:3] == 4'h0 || a[6:3] == 4'hF)) return 1'b0;
    for (int j = int'(m_smsk) + 1; j <= 7; j++)
      if (a[j-1] != m_saddr[j-1]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_byte(logic [7:0] b, logic first,
                            output logic ev, output logic [1:0] eid, output logic erw);
    ev = 1'b0; eid = 2'd0; erw = 1'b0;
    if (first) begin
      if (m_pen && m_pmode && b[7:3] == 5'b11110 && b[2:1] == m_paddr[9:8]) begin
        m_hdr = 1'b1; m_hrw = b[0];
      end else begin
        m_hdr = 1'b0; ev = 1'b1; erw = b[0];
        if (m_pen && !m_pmode && b[7:1] == m_paddr[7:1]) eid = 2'd1;
        else if (sec_model(b[7:1])) eid = 2'd2;
      end
    end else if (m_hdr) begin
      m_hdr = 1'b0; ev = 1'b1; erw = m_hrw;
      eid = (b == m_paddr[7:0]) ? 2'd1 : 2'd0;
    end
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    #1;
    while (cfg_wait) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    model_wr(sel, d);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b, logic first, string req);
    logic ev, erw;
    logic [1:0] eid;
    @(negedge clk);
    addr_byte_vld = 1'b1; addr_byte = b; addr_first = first;
    @(negedge clk);
    addr_byte_vld = 1'b0;
    model_byte(b, first, ev, eid, erw);
    chk(req, "match_vld", int'(match_vld), int'(ev));
    if (ev) begin
      chk(req, "match_ack", int'(match_ack), int'(eid != 2'd0));
      chk(req, "match_id", int'(match_id), int'(eid));
      chk(req, "match_rw", int'(match_rw), int'(erw));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    int unsigned seed;
    int n;
    logic [7:0] b;
    seed = $urandom(32'd20240611);
    m_pen = 0; m_pmode = 0; m_sen = 0; m_hdr = 0; m_hrw = 0;
    m_paddr = '0; m_smsk = '0; m_saddr = '0;
    rst_n = 1'b0; cfg_wr_en = 0; cfg_sel = 0; cfg_wdata = '0;
    addr_byte_vld = 0; addr_first = 0; addr_byte = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "cfg_wait after reset", int'(cfg_wait), 0);
    chk("R1", "match_vld after reset", int'(match_vld), 0);
    send(8'h00, 1'b1, "R1");
    send(8'hA4, 1'b1, "R1");
    send(8'hFF, 1'b1, "R1");

    // R2: 7-bit primary, bits 9, 8, 0 set but ignored
    wr(1'b0, 16'h8000 | 16'h0300 | 16'h00B5);
    send(8'hB4, 1'b1, "R2");
    send(8'hB5, 1'b1, "R2");
    send(8'hB6, 1'b1, "R2");

    // R10: stray non-first byte gives no strobe
    send(8'hB4, 1'b0, "R10");

    // R4: locked while enabled, enable still writable
    wr(1'b0, 16'h8000 | 16'h0422);
    send(8'hB4, 1'b1, "R4");
    send(8'h22, 1'b1, "R4");
    wr(1'b0, 16'h0000);
    send(8'hB4, 1'b1, "R4");

    // R3: 10-bit mode, address 0x2C7
    wr(1'b0, 16'h8000 | 16'h0400 | 16'h02C7);
    send(8'hF5, 1'b1, "R3");
    send(8'hC7, 1'b0, "R3");
    send(8'hF4, 1'b1, "R3");
    send(8'hC6, 1'b0, "R3");
    send(8'hF1, 1'b1, "R3");
    // R10: new first byte abandons pending header
    send(8'hF4, 1'b1, "R10");
    send(8'h10, 1'b1, "R10");
    send(8'hC7, 1'b0, "R10");

    // R11: secondary disabled, would match 0x5A
    wr(1'b1, 16'h005A);
    send(8'h5A, 1'b1, "R11");

    // R9: back-to-back writes stall
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'h0350;
    @(posedge clk); #1;
    model_wr(1'b1, 16'h0350);
    cfg_wdata = 16'h8000 | 16'h0350;
    chk("R9", "cfg_wait during apply", int'(cfg_wait), 1);
    n = 0;
    while (cfg_wait) begin @(negedge clk); #1; n++; end
    chk("R9", "wait length", n, LAT + 1);
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    model_wr(1'b1, 16'h8000 | 16'h0350);
    repeat (LAT + 1) @(negedge clk);
    chk("R9", "cfg_wait idle", int'(cfg_wait), 0);

    // R5: mask 3 on 0x50: bits [7:4] compared
    send(8'h5E, 1'b1, "R5");
    send(8'h40, 1'b1, "R5");

    // R7: locked secondary
    wr(1'b1, 16'h8000 | 16'h0000 | 16'h0022);
    send(8'h5E, 1'b1, "R7");
    send(8'h22, 1'b1, "R7");

    // R6: reserved groups refused with mask, compared without
    wr(1'b1, 16'h0000);
    wr(1'b1, 16'h8000 | 16'h0700);
    send(8'h0A, 1'b1, "R6");
    send(8'hF2, 1'b1, "R6");
    send(8'h6A, 1'b1, "R6");
    wr(1'b1, 16'h0000);
    wr(1'b1, 16'h8000 | 16'h000A);
    send(8'h0A, 1'b1, "R6");

    // R8: both settings match a 7-bit byte
    wr(1'b0, 16'h0000);
    wr(1'b0, 16'h8000 | 16'h000A);
    send(8'h0B, 1'b1, "R8");
    // R8: header byte the secondary would accept still goes 10-bit
    wr(1'b0, 16'h0000);
    wr(1'b0, 16'h8000 | 16'h0400 | 16'h0133);
    wr(1'b1, 16'h0000);
    wr(1'b1, 16'h8000 | 16'h00F2);
    send(8'hF2, 1'b1, "R8");
    send(8'h33, 1'b0, "R8");

    // R5: random configuration and address traffic against the model
    for (int it = 0; it < 400; it++) begin
      int unsigned r;
      r = $urandom % 8;
      if (r == 0) wr(1'b0, 16'($urandom));
      else if (r == 1) wr(1'b1, 16'($urandom));
      r = $urandom % 6;
      case (r)
        0: b = {m_paddr[7:1], 1'($urandom)};
        1: b = {m_saddr ^ 7'($urandom % 8), 1'($urandom)};
        2: b = {5'b11110, m_paddr[9:8], 1'($urandom)};
        3: b = m_hdr ? m_paddr[7:0] : 8'($urandom);
        4: b = {(($urandom % 2) != 0) ? 4'hF : 4'h0, 4'($urandom)};
        default: b = 8'($urandom);
      endcase
      send(b, (($urandom % 4) != 0) || !m_hdr ? 1'b1 : 1'b0, "R5");
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule